// File: doc/BRIEF.md
# GbE Idle Rate Match FIFO

This block is the elastic buffer in a 1000BASE-X style receive path. Decoded symbols arrive on the recovered clock, one per cycle, each an 8-bit value with a control flag. They leave on the local clock, one per cycle. The two clocks share a nominal 125 MHz rate, and each may be off by up to ±100 ppm, so the worst-case relative offset is 200 ppm. Write and read pointers cross between the domains as Gray code through two-flop synchronizers. Each domain computes its own fill level.

Compensation acts only on the /I2/ idle ordered set, which is K28.5 followed by D16.2, and always on both symbols together. When the writer sees the fill above a high mark, it drops any /I2/ pair arriving in its input. When the reader sees the fill below a low mark, it emits one extra /I2/ pair right after it has read an /I2/. It repeats this while the fill stays low, so an odd shortfall is rounded up to whole sets. The /I1/ set and data symbols are never touched. Nothing is compensated until the word-alignment sync input is high.

Reset pre-loads half of the storage with /I2/ pairs, so the buffer starts at its midpoint and emits idles first. If the buffer ever overflows or runs dry, it does not try to recover. It raises a sticky full or empty flag and freezes that side until the active-low reset is applied again.

Top module: `idle_rate_matcher`

## Requirements
- R1: While reset is held, full_o and empty_o are low. After reset, the first DEPTH/2 output symbols alternate K28.5, D16.2, starting with K28.5.
- R2: With both clocks at the same rate, every data symbol and every /I1/ pair leaves in the order it arrived, unchanged, and no /I2/ pair is removed.
- R3: With sync high and the write clock faster, /I2/ pairs are deleted. No data or /I1/ symbol is lost, and neither flag rises.
- R4: With sync high and the read clock faster, extra /I2/ pairs are emitted, only directly after an /I2/ has been read. The data order is kept, and neither flag rises.
- R5: Symbol encodings: K28.5 is k=1 with byte 0xBC, D16.2 is k=0 with byte 0x50, and D5.6 is k=0 with byte 0xC5. Outside an error, an output K28.5 is always followed at once by D16.2 or D5.6, and /I1/ pairs are never added or removed.
- R6: With sync low, no deletion occurs. A faster write clock therefore leads to full_o rising.
- R7: With sync low, no insertion occurs. A faster read clock therefore leads to empty_o rising.
- R8: Once full_o rises, it stays high until reset, and the write-side fill never exceeds DEPTH.
- R9: Once empty_o rises, it stays high until reset, and the reader never reads past the writer.
- R10: Applying reset after a full or empty event clears both flags, and normal operation resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk_i | input | 1 | Recovered (write) clock |
| rd_clk_i | input | 1 | Local (read) clock |
| rst_ni | input | 1 | Asynchronous active-low receive reset, both domains |
| sync_ok_i | input | 1 | Word alignment achieved; write-clock domain |
| wr_k_i | input | 1 | Control flag of the incoming symbol |
| wr_data_i | input | 8 | Incoming decoded byte |
| rd_k_o | output | 1 | Control flag of the outgoing symbol |
| rd_data_o | output | 8 | Outgoing decoded byte |
| full_o | output | 1 | Sticky overflow flag; write-clock domain |
| empty_o | output | 1 | Sticky underflow flag; read-clock domain |

## Verification
The pairing property assumes a well-formed incoming stream, in which K28.5 appears only as the first symbol of an /I1/ or /I2/ set and is always followed by its tail. The stimulus builds every frame from data symbols with the control flag clear, one /I1/ pair and four /I2/ pairs, so this holds by construction. The fill-bound properties assume a relative clock offset small enough that pointer updates seen through the synchronizers never step by more than the threshold margins. The bench keeps the offset at about one percent, which is far larger than 200 ppm but still well inside those margins.

// File: rtl/rm_pkg.sv
package rm_pkg;
  typedef struct packed {
    logic       k;
    logic [7:0] d;
  } sym_t;

  localparam sym_t SYM_COMMA   = '{k: 1'b1, d: 8'hBC};
  localparam sym_t SYM_I2_TAIL = '{k: 1'b0, d: 8'h50};
  localparam sym_t SYM_I1_TAIL = '{k: 1'b0, d: 8'hC5};

  typedef enum logic [1:0] {RD_PASS, RD_EXTRA_K, RD_EXTRA_D} rd_mode_e;
endpackage

// File: rtl/rm_sync.sv
module rm_sync #(
  parameter int             W   = 1,
  parameter logic [W-1:0]   RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST;
      sync_q <= RST;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/rm_store.sv
module rm_store
  import rm_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wr_clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  sym_t          wdata_i,
  input  logic [AW-1:0] raddr_i,
  output sym_t          rdata_o
);
  sym_t mem_q [DEPTH];

  // reset image: alternating comma / I2 tail, i.e. a run of idle pairs
  always_ff @(posedge wr_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++)
        mem_q[i] <= (i % 2 == 0) ? SYM_COMMA : SYM_I2_TAIL;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rm_wr_side.sv
module rm_wr_side
  import rm_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int HI_MARK = DEPTH - 4,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_ok_i,
  input  sym_t          sym_i,
  input  logic [PW-1:0] rptr_gray_i,
  output logic [PW-1:0] wptr_gray_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output sym_t          wdata_o,
  output logic [PW-1:0] fill_o,
  output logic          full_o
);
  localparam logic [PW-1:0] RST_PTR  = PW'(DEPTH / 2);
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
  localparam logic [PW-1:0] HI_LVL   = PW'(HI_MARK);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wptr_q, gray_q, rptr_bin, fill, wptr_nxt;
  sym_t          hold_q;
  logic          hold_vld_q, hold_skip_q, full_q;
  logic          drop_pair, push, blocked;

  assign rptr_bin = g2b(rptr_gray_i);
  assign fill     = wptr_q - rptr_bin;
  assign wptr_nxt = wptr_q + PW'(1);

  // one-symbol lookahead: the held comma is dropped together with the tail at the input
  assign drop_pair = hold_vld_q && !hold_skip_q && (hold_q == SYM_COMMA) &&
                     (sym_i == SYM_I2_TAIL) && sync_ok_i && (fill >= HI_LVL);
  assign push      = hold_vld_q && !hold_skip_q && !drop_pair && !full_q;
  assign blocked   = push && (fill == FULL_LVL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q      <= RST_PTR;
      gray_q      <= RST_PTR ^ (RST_PTR >> 1);
      hold_q      <= SYM_I2_TAIL;
      hold_vld_q  <= 1'b0;
      hold_skip_q <= 1'b0;
      full_q      <= 1'b0;
    end else begin
      hold_q      <= sym_i;
      hold_vld_q  <= 1'b1;
      hold_skip_q <= drop_pair;
      if (blocked) begin
        full_q <= 1'b1;
      end else if (push) begin
        wptr_q <= wptr_nxt;
        gray_q <= wptr_nxt ^ (wptr_nxt >> 1);
      end
    end
  end

  assign wptr_gray_o = gray_q;
  assign we_o        = push && !blocked;
  assign waddr_o     = wptr_q[AW-1:0];
  assign wdata_o     = hold_q;
  assign fill_o      = fill;
  assign full_o      = full_q;
endmodule

// File: rtl/rm_rd_side.sv
module rm_rd_side
  import rm_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int LO_MARK = 4,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_ok_i,
  input  logic [PW-1:0] wptr_gray_i,
  input  sym_t          rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [PW-1:0] rptr_gray_o,
  output sym_t          sym_o,
  output logic [PW-1:0] fill_o,
  output logic          empty_o
);
  localparam logic [PW-1:0] LO_LVL = PW'(LO_MARK);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] rptr_q, gray_q, wptr_bin, fill, rptr_nxt;
  sym_t          out_q;
  rd_mode_e      mode_q;
  logic          after_comma_q, empty_q, starving;

  assign wptr_bin = g2b(wptr_gray_i);
  assign fill     = wptr_bin - rptr_q;
  assign rptr_nxt = rptr_q + PW'(1);
  assign starving = fill < LO_LVL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q        <= '0;
      gray_q        <= '0;
      out_q         <= SYM_I2_TAIL;
      mode_q        <= RD_PASS;
      after_comma_q <= 1'b0;
      empty_q       <= 1'b0;
    end else if (!empty_q) begin
      case (mode_q)
        RD_PASS: begin
          if (fill == '0) begin
            empty_q <= 1'b1;
          end else begin
            out_q         <= rdata_i;
            rptr_q        <= rptr_nxt;
            gray_q        <= rptr_nxt ^ (rptr_nxt >> 1);
            after_comma_q <= (rdata_i == SYM_COMMA);
            // a complete I2 just left the store: room for an extra pair
            if (after_comma_q && (rdata_i == SYM_I2_TAIL) && sync_ok_i && starving)
              mode_q <= RD_EXTRA_K;
          end
        end
        RD_EXTRA_K: begin
          out_q  <= SYM_COMMA;
          mode_q <= RD_EXTRA_D;
        end
        RD_EXTRA_D: begin
          out_q  <= SYM_I2_TAIL;
          mode_q <= (sync_ok_i && starving) ? RD_EXTRA_K : RD_PASS;
        end
        default: mode_q <= RD_PASS;
      endcase
    end
  end

  assign raddr_o     = rptr_q[AW-1:0];
  assign rptr_gray_o = gray_q;
  assign sym_o       = out_q;
  assign fill_o      = fill;
  assign empty_o     = empty_q;
endmodule

// File: rtl/idle_rate_matcher.sv
module idle_rate_matcher
  import rm_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int HI_MARK = DEPTH - 4,
  parameter int LO_MARK = 4
) (
  input  logic       wr_clk_i,
  input  logic       rd_clk_i,
  input  logic       rst_ni,
  input  logic       sync_ok_i,
  input  logic       wr_k_i,
  input  logic [7:0] wr_data_i,
  output logic       rd_k_o,
  output logic [7:0] rd_data_o,
  output logic       full_o,
  output logic       empty_o
);
  localparam int            AW       = $clog2(DEPTH);
  localparam int            PW       = AW + 1;
  localparam logic [PW-1:0] HALF     = PW'(DEPTH / 2);
  localparam logic [PW-1:0] HALF_GRY = HALF ^ (HALF >> 1);

  sym_t          in_sym, wdata, rdata, out_sym;
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wptr_gray, rptr_gray, wptr_gray_rd, rptr_gray_wr;
  logic [PW-1:0] wr_fill, rd_fill;
  logic          sync_rd;

  assign in_sym = '{k: wr_k_i, d: wr_data_i};

  rm_sync #(.W(PW), .RST('0)) u_rptr_to_wr (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .d_i(rptr_gray), .q_o(rptr_gray_wr)
  );

  rm_sync #(.W(PW), .RST(HALF_GRY)) u_wptr_to_rd (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .d_i(wptr_gray), .q_o(wptr_gray_rd)
  );

  rm_sync #(.W(1), .RST(1'b0)) u_sync_to_rd (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .d_i(sync_ok_i), .q_o(sync_rd)
  );

  rm_wr_side #(.DEPTH(DEPTH), .HI_MARK(HI_MARK)) u_wr (
    .clk_i      (wr_clk_i),
    .rst_ni     (rst_ni),
    .sync_ok_i  (sync_ok_i),
    .sym_i      (in_sym),
    .rptr_gray_i(rptr_gray_wr),
    .wptr_gray_o(wptr_gray),
    .we_o       (we),
    .waddr_o    (waddr),
    .wdata_o    (wdata),
    .fill_o     (wr_fill),
    .full_o     (full_o)
  );

  rm_store #(.DEPTH(DEPTH)) u_store (
    .wr_clk_i(wr_clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  rm_rd_side #(.DEPTH(DEPTH), .LO_MARK(LO_MARK)) u_rd (
    .clk_i      (rd_clk_i),
    .rst_ni     (rst_ni),
    .sync_ok_i  (sync_rd),
    .wptr_gray_i(wptr_gray_rd),
    .rdata_i    (rdata),
    .raddr_o    (raddr),
    .rptr_gray_o(rptr_gray),
    .sym_o      (out_sym),
    .fill_o     (rd_fill),
    .empty_o    (empty_o)
  );

  assign rd_k_o    = out_sym.k;
  assign rd_data_o = out_sym.d;
endmodule

// File: rtl/rm_checker.sv
module rm_checker #(
  parameter int DEPTH = 32,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input logic          wr_clk_i,
  input logic          rd_clk_i,
  input logic          rst_ni,
  input logic          full_i,
  input logic          empty_i,
  input logic          rd_k_i,
  input logic [7:0]    rd_data_i,
  input logic [PW-1:0] wr_fill_i,
  input logic [PW-1:0] rd_fill_i
);
  assert_full_sticky_R8: assert property (
    @(posedge wr_clk_i) disable iff (!rst_ni) full_i |=> full_i);

  assert_empty_sticky_R9: assert property (
    @(posedge rd_clk_i) disable iff (!rst_ni) empty_i |=> empty_i);

  assert_comma_paired_R5: assert property (
    @(posedge rd_clk_i) disable iff (!rst_ni)
      (rd_k_i && rd_data_i == 8'hBC && !empty_i) |=>
      (empty_i || (!rd_k_i && (rd_data_i == 8'h50 || rd_data_i == 8'hC5))));

  assert_no_overflow_R8: assert property (
    @(posedge wr_clk_i) disable iff (!rst_ni) wr_fill_i <= PW'(DEPTH));

  assert_no_overread_R9: assert property (
    @(posedge rd_clk_i) disable iff (!rst_ni) rd_fill_i <= PW'(DEPTH));
endmodule

bind idle_rate_matcher rm_checker #(.DEPTH(DEPTH)) u_rm_checker (
  .wr_clk_i (wr_clk_i),
  .rd_clk_i (rd_clk_i),
  .rst_ni   (rst_ni),
  .full_i   (full_o),
  .empty_i  (empty_o),
  .rd_k_i   (rd_k_o),
  .rd_data_i(rd_data_o),
  .wr_fill_i(wr_fill),
  .rd_fill_i(rd_fill)
);

// File: tb/idle_rate_matcher_test.sv
`timescale 1ns/1ps
module idle_rate_matcher_test;
  localparam int DEPTH = 32;
  localparam logic [8:0] K285 = 9'h1BC;
  localparam logic [8:0] D162 = 9'h050;
  localparam logic [8:0] D56  = 9'h0C5;

  logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0, sync_ok = 1'b0;
  logic wr_k = 1'b0;
  logic [7:0] wr_d = 8'h00;
  logic rd_k, full, empty;
  logic [7:0] rd_d;
  real rd_half = 2.5;

  int n_checks = 0, n_err = 0;
  int in_i2, out_i2, in_i1, out_i1, pair_err;
  bit pend, gen_done, compare_on;
  bit seen_full, full_drop, seen_empty, empty_drop;
  logic [8:0] exp_q[$];

  idle_rate_matcher #(.DEPTH(DEPTH)) uut (
    .wr_clk_i(wr_clk), .rd_clk_i(rd_clk), .rst_ni(rst_n), .sync_ok_i(sync_ok),
    .wr_k_i(wr_k), .wr_data_i(wr_d), .rd_k_o(rd_k), .rd_data_o(rd_d),
    .full_o(full), .empty_o(empty)
  );

  always #2.5 wr_clk = ~wr_clk;
  initial begin
    #1.3;
    forever #(rd_half) rd_clk = ~rd_clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmp(input logic [8:0] s, input string tag);
    if (!compare_on) return;
    if (exp_q.size() == 0) begin
      check(1'b0, tag, int'(s), -1);
    end else begin
      logic [8:0] e;
      e = exp_q.pop_front();
      check(s == e, tag, int'(s), int'(e));
    end
  endtask

  task automatic take(input logic [8:0] s, input string tag);
    if (pend) begin
      pend = 1'b0;
      if (s == D162) out_i2++;
      else if (s == D56) begin
        out_i1++;
        cmp(K285, tag);
        cmp(D56, tag);
      end else pair_err++;
    end else if (s == K285) pend = 1'b1;
    else cmp(s, tag);
  endtask

  task automatic gen(input int n);
    for (int i = 0; i < n; i++) begin
      int pos;
      logic [8:0] s;
      pos = i % 30;
      if (pos < 20) begin
        s = {1'b0, 8'(i * 37 + 11)};
        exp_q.push_back(s);
      end else if (pos == 20) begin
        s = K285;
        exp_q.push_back(s);
      end else if (pos == 21) begin
        s = D56;
        exp_q.push_back(s);
        in_i1++;
      end else begin
        s = (pos % 2 == 0) ? K285 : D162;
        if (pos % 2 == 1) in_i2++;
      end
      wr_k = s[8];
      wr_d = s[7:0];
      @(negedge wr_clk);
    end
    gen_done = 1'b1;
  endtask

  task automatic monitor(input string tag);
    int idx;
    logic [8:0] s;
    idx = 0;
    @(posedge rd_clk);
    while (!gen_done) begin
      @(negedge rd_clk);
      s = {rd_k, rd_d};
      if (idx < DEPTH / 2)
        check(s == ((idx % 2 == 0) ? K285 : D162), "R1 prefill idle", int'(s),
              int'((idx % 2 == 0) ? K285 : D162));
      idx++;
      take(s, tag);
      if (full) seen_full = 1'b1; else if (seen_full) full_drop = 1'b1;
      if (empty) seen_empty = 1'b1; else if (seen_empty) empty_drop = 1'b1;
    end
  endtask

  task automatic do_reset(input string tag);
    rst_n = 1'b0;
    repeat (3) @(negedge wr_clk);
    check(full == 1'b0, tag, int'(full), 0);
    check(empty == 1'b0, tag, int'(empty), 0);
    exp_q.delete();
    in_i2 = 0; out_i2 = 0; in_i1 = 0; out_i1 = 0; pair_err = 0;
    pend = 0; gen_done = 0;
    seen_full = 0; full_drop = 0; seen_empty = 0; empty_drop = 0;
    rst_n = 1'b1;
  endtask

  task automatic run(input real half, input bit sy, input int n, input bit cmp_on,
                     input string rst_tag, input string tag);
    rd_half = half;
    sync_ok = sy;
    compare_on = cmp_on;
    do_reset(rst_tag);
    fork
      gen(n);
      monitor(tag);
    join
  endtask

  task automatic ok_run_checks(input string tag);
    check(pair_err == 0, "R5 pairing", pair_err, 0);
    check(out_i1 <= in_i1 && out_i1 + 2 >= in_i1, "R5 I1 count", out_i1, in_i1);
    check(!seen_full, {tag, " no full"}, int'(seen_full), 0);
    check(!seen_empty, {tag, " no empty"}, int'(seen_empty), 0);
  endtask

  initial begin
    repeat (190000) @(posedge wr_clk);
    n_err++;
    n_checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    // R1/R2: equal rates
    run(2.5, 1'b1, 6000, 1'b1, "R1 reset flags", "R2 data order");
    ok_run_checks("R2");
    check(out_i2 >= in_i2 && out_i2 <= in_i2 + DEPTH / 4, "R2 no I2 change", out_i2, in_i2);

    // R3: writer faster, sync high -> deletions
    run(2.525, 1'b1, 8000, 1'b1, "R1 reset flags", "R3 data order");
    ok_run_checks("R3");
    check(out_i2 + 12 <= in_i2, "R3 deletions", out_i2, in_i2);

    // R4: reader faster, sync high -> insertions
    run(2.475, 1'b1, 8000, 1'b1, "R1 reset flags", "R4 data order");
    ok_run_checks("R4");
    check(out_i2 >= in_i2 + 20, "R4 insertions", out_i2, in_i2);

    // R6/R8: no sync, writer faster -> sticky full
    run(2.525, 1'b0, 5000, 1'b0, "R1 reset flags", "R6");
    check(seen_full, "R6 full raised", int'(seen_full), 1);
    check(!full_drop, "R8 full sticky", int'(full_drop), 0);
    check(full == 1'b1, "R8 full held", int'(full), 1);

    // R7/R9: no sync, reader faster -> sticky empty; reset first clears R10
    run(2.475, 1'b0, 5000, 1'b0, "R10 reset after full", "R7");
    check(seen_empty, "R7 empty raised", int'(seen_empty), 1);
    check(!empty_drop, "R9 empty sticky", int'(empty_drop), 0);
    check(empty == 1'b1, "R9 empty held", int'(empty), 1);

    // R10: recovery after error
    run(2.5, 1'b1, 3000, 1'b1, "R10 reset after empty", "R10 data order");
    ok_run_checks("R10");

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule